// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block holds the eight-bit status register of a serial memory and makes every decision about whether a write is allowed. A command front end supplies a one-cycle completion strobe with the opcode of each finished command (the strobe marks chip-select rising at the end of that command), plus the data byte of a status write. From these strobes the block keeps the write-enable latch, the auto-increment programming flag, the protection level and the lock-down bit up to date.

The block also decodes the protection level into a read-only region at the top of the address space. It returns three permission levels to the array sequencer: one for a program or erase at the presented target address, one for a whole-array erase, and one for a status write about to complete. The write-protect pin decides whether the lock-down bit is in force. The busy flag from the array sequencer is shown in bit 0 and blocks program and erase permission while it is high.

Top module: `sg_top`

## Requirements
- R1: After reset the register reads 0x1C: busy 0 (bit0), write-enable 0 (bit1), protection level bits 2..4 = 111, spare protection bit 5 = 0, auto-increment flag 0 (bit6), lock-down 0 (bit7).
- R2: Bit 0 of the register always shows the busy input.
- R3: Completion of opcode 06h sets the write-enable bit. Completion of opcode 04h clears both the write-enable bit and the auto-increment flag. No other event sets the write-enable bit.
- R4: Completion of a byte program (02h), any erase (20h, 52h, D8h, 60h, C7h) or a status write (01h) clears the write-enable bit. Completion of an auto-increment program (ADh) while write-enable is 1 sets the auto-increment flag. A pulse on the end-of-auto-increment input clears both bits.
- R5: A status write (01h) changes the register only when the command completed just before it was 06h or 50h. Completion of any other command removes that permission. `sr_wr_ok` shows this permission.
- R6: While the write-protect pin is low and lock-down is 1, status writes change no bit.
- R7: While the write-protect pin is high, lock-down has no effect. One accepted status write loads data bits 2..5 into the protection bits and data bit 7 into lock-down, even when that write sets lock-down. Data bits 0, 1 and 6 are ignored.
- R8: For a protection level n (bits 4:2) from 1 to 6, addresses at or above 2^22 − 2^(15+n) are protected. Level 0 protects nothing and level 7 protects every address.
- R9: Bit 5 does not change the protected range.
- R10: `pe_ok` is 1 exactly when write-enable is 1, busy is 0 and the target address is not protected.
- R11: `chip_erase_ok` is 1 exactly when write-enable is 1, busy is 0 and status bits 5..2 are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset to power-on values |
| op_done | input | 1 | One-cycle strobe: a command has completed |
| op_code | input | 8 | Opcode of the completed command |
| op_data | input | 8 | Data byte of a completed status write |
| aai_end | input | 1 | One-cycle strobe: auto-increment programming has ended |
| wp_n | input | 1 | Write-protect pin, active low |
| busy_in | input | 1 | Array operation in progress |
| tgt_addr | input | 22 | Target address of a pending program or erase |
| stat_q | output | 8 | Status register value |
| pe_ok | output | 1 | Program/erase at tgt_addr is allowed |
| chip_erase_ok | output | 1 | Whole-array erase is allowed |
| sr_wr_ok | output | 1 | A status write completing now would be accepted |

## Verification
The bench uses the default parameters: a 22-bit address and a 3-bit protection level field. This gives a 4M-byte space, in which every one of the six fractional boundaries sits at a distinct address. For each level, the bench probes the first protected address and the address just below it. Levels 0 and 7 are probed at the extreme addresses. The bench also covers the lock-down rules in both pin states, and the cases where the arm step is missing or cancelled.

// File: rtl/sg_pkg.sv
package sg_pkg;
   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_EWSR  = 8'h50;
   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_PROG  = 8'h02;
   localparam logic [7:0] OP_AAI   = 8'hAD;
   localparam logic [7:0] OP_SE4K  = 8'h20;
   localparam logic [7:0] OP_BE32  = 8'h52;
   localparam logic [7:0] OP_BE64  = 8'hD8;
   localparam logic [7:0] OP_CE_A  = 8'h60;
   localparam logic [7:0] OP_CE_B  = 8'hC7;

   typedef enum logic [1:0] {
      OPK_OTHER = 2'd0,
      OPK_CLRW  = 2'd1,
      OPK_AAI   = 2'd2
   } op_kind_e;

   function automatic op_kind_e classify(input logic [7:0] op);
      case (op)
         OP_PROG, OP_SE4K, OP_BE32, OP_BE64, OP_CE_A, OP_CE_B, OP_WRSR:
            classify = OPK_CLRW;
         OP_AAI:  classify = OPK_AAI;
         default: classify = OPK_OTHER;
      endcase
   endfunction
endpackage

// File: rtl/sg_prot_decode.sv
module sg_prot_decode #(
   parameter int ADDR_W = 22,
   parameter int LVL_W  = 3
) (
   input  logic [LVL_W-1:0]  lvl,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int NLEV = (1 << LVL_W) - 2;

   generate
      if (ADDR_W <= NLEV) begin : g_bad
         $error("sg_prot_decode: ADDR_W must exceed the fractional level count");
      end
   endgenerate

   logic [NLEV:1] top_ones;

   generate
      for (genvar k = 1; k <= NLEV; k++) begin : g_lev
         assign top_ones[k] = &addr[ADDR_W-1 : ADDR_W-1-NLEV+k];
      end
   endgenerate

   always_comb begin
      hit = 1'b0;
      if (lvl == {LVL_W{1'b1}}) begin
         hit = 1'b1;
      end else begin
         for (int k = 1; k <= NLEV; k++) begin
            if (int'(lvl) == k) hit = top_ones[k];
         end
      end
   end
endmodule

// File: rtl/sg_stat_core.sv
module sg_stat_core
   import sg_pkg::*;
#(
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_done,
   input  logic [7:0]       op_code,
   input  logic [7:0]       op_data,
   input  logic             aai_end,
   input  logic             wp_n,
   output logic             wel,
   output logic             aai,
   output logic             bpl,
   output logic [LVL_W:0]   bp,
   output logic             sr_wr_ok
);
   localparam int BP_LO = 2;
   localparam int BP_HI = BP_LO + LVL_W;

   generate
      if (BP_HI > 6) begin : g_bad
         $error("sg_stat_core: protection field overlaps upper status bits");
      end
   endgenerate

   logic     armed;
   op_kind_e kind;

   assign kind     = classify(op_code);
   assign sr_wr_ok = armed & (wp_n | ~bpl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel   <= 1'b0;
         aai   <= 1'b0;
         bpl   <= 1'b0;
         bp    <= {1'b0, {LVL_W{1'b1}}};
         armed <= 1'b0;
      end else begin
         if (op_done) begin
            armed <= (op_code == OP_WREN) || (op_code == OP_EWSR);
            if (op_code == OP_WREN) wel <= 1'b1;
            if (op_code == OP_WRDI) begin
               wel <= 1'b0;
               aai <= 1'b0;
            end
            if (kind == OPK_CLRW) wel <= 1'b0;
            if (kind == OPK_AAI && wel) aai <= 1'b1;
            if (op_code == OP_WRSR && sr_wr_ok) begin
               bp  <= op_data[BP_HI:BP_LO];
               bpl <= op_data[7];
            end
         end
         if (aai_end) begin
            wel <= 1'b0;
            aai <= 1'b0;
         end
      end
   end

   // R3
   wel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(op_done && op_code == OP_WREN));

   // R6
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bpl && !wp_n) |=> (bpl && $stable(bp)));

   // R5
   unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done && op_code == OP_WRSR && !sr_wr_ok) |=> ($stable(bp) && $stable(bpl)));
endmodule

// File: rtl/sg_top.sv
module sg_top
   import sg_pkg::*;
#(
   parameter int ADDR_W = 22,
   parameter int LVL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_done,
   input  logic [7:0]        op_code,
   input  logic [7:0]        op_data,
   input  logic              aai_end,
   input  logic              wp_n,
   input  logic              busy_in,
   input  logic [ADDR_W-1:0] tgt_addr,
   output logic [7:0]        stat_q,
   output logic              pe_ok,
   output logic              chip_erase_ok,
   output logic              sr_wr_ok
);
   logic             wel, aai, bpl, prot_hit;
   logic [LVL_W:0]   bp;

   sg_stat_core #(.LVL_W(LVL_W)) core_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_done  (op_done),
      .op_code  (op_code),
      .op_data  (op_data),
      .aai_end  (aai_end),
      .wp_n     (wp_n),
      .wel      (wel),
      .aai      (aai),
      .bpl      (bpl),
      .bp       (bp),
      .sr_wr_ok (sr_wr_ok)
   );

   sg_prot_decode #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) dec_i (
      .lvl  (bp[LVL_W-1:0]),
      .addr (tgt_addr),
      .hit  (prot_hit)
   );

   assign stat_q        = {bpl, aai, bp, wel, busy_in};
   assign pe_ok         = wel & ~busy_in & ~prot_hit;
   assign chip_erase_ok = wel & ~busy_in & (bp == '0);

   // R10
   pe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pe_ok |-> (stat_q[1] && !busy_in));

   // R11
   ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chip_erase_ok |-> (stat_q[5:2] == 4'd0 && !busy_in));
endmodule

// File: tb/sg_top_tb_top.sv
module sg_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_done = 1'b0;
   logic [7:0]  op_code = 8'h00;
   logic [7:0]  op_data = 8'h00;
   logic        aai_end = 1'b0;
   logic        wp_n = 1'b1;
   logic        busy_in = 1'b0;
   logic [21:0] tgt_addr = '0;
   logic [7:0]  stat_q;
   logic        pe_ok, chip_erase_ok, sr_wr_ok;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sg_top dut_i (
      .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_code(op_code),
      .op_data(op_data), .aai_end(aai_end), .wp_n(wp_n), .busy_in(busy_in),
      .tgt_addr(tgt_addr), .stat_q(stat_q), .pe_ok(pe_ok),
      .chip_erase_ok(chip_erase_ok), .sr_wr_ok(sr_wr_ok)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cmd(input logic [7:0] op, input logic [7:0] dat = 8'h00);
      @(negedge clk);
      op_code = op; op_data = dat; op_done = 1'b1;
      @(negedge clk);
      op_done = 1'b0;
   endtask

   task automatic set_stat(input logic [7:0] v);
      cmd(8'h50);
      cmd(8'h01, v);
   endtask

   task automatic t_reset;
      chk("R1 reset value", stat_q, 8'h1C);
      busy_in = 1'b1; #1;
      chk("R2 busy bit", stat_q[0], 1'b1);
      busy_in = 1'b0; #1;
      chk("R2 busy clear", stat_q[0], 1'b0);
   endtask

   task automatic t_wel;
      cmd(8'h06);
      chk("R3 WREN sets WEL", stat_q, 8'h1E);
      chk("R5 armed after WREN", sr_wr_ok, 1'b1);
      cmd(8'h01, 8'h43);
      chk("R7 WRSR after WREN, ignored bits", stat_q, 8'h00);
      cmd(8'h06);
      cmd(8'h02);
      chk("R4 program clears WEL", stat_q[1], 1'b0);
      cmd(8'h06);
      cmd(8'hD8);
      chk("R4 erase clears WEL", stat_q[1], 1'b0);
   endtask

   task automatic t_arm;
      cmd(8'h01, 8'h0C);
      chk("R5 WRSR without arm ignored", stat_q, 8'h00);
      cmd(8'h50);
      cmd(8'h05);
      chk("R5 arm cancelled", sr_wr_ok, 1'b0);
      cmd(8'h01, 8'h0C);
      chk("R5 cancelled arm ignored", stat_q, 8'h00);
   endtask

   task automatic t_prot;
      for (int n = 0; n < 8; n++) begin
         set_stat(8'(n << 2));
         cmd(8'h06);
         if (n == 0) begin
            tgt_addr = 22'h3FFFFF; #1;
            chk("R8 level 0 top allowed", pe_ok, 1'b1);
         end else if (n == 7) begin
            tgt_addr = 22'h000000; #1;
            chk("R8 level 7 bottom denied", pe_ok, 1'b0);
         end else begin
            tgt_addr = 22'(32'h400000 - (32'h1 << (15 + n))); #1;
            chk("R8 first protected", pe_ok, 1'b0);
            tgt_addr = tgt_addr - 22'd1; #1;
            chk("R8 below boundary", pe_ok, 1'b1);
         end
         cmd(8'h04);
      end
      set_stat(8'h20);
      cmd(8'h06);
      tgt_addr = 22'h3FFFFF; #1;
      chk("R9 BP3 no range", pe_ok, 1'b1);
      chk("R11 BP3 blocks chip erase", chip_erase_ok, 1'b0);
      busy_in = 1'b1; #1;
      chk("R10 busy blocks", pe_ok, 1'b0);
      busy_in = 1'b0;
      set_stat(8'h00);
      chk("R11 WEL off after WRSR", chip_erase_ok, 1'b0);
      cmd(8'h06); #1;
      chk("R11 chip erase allowed", chip_erase_ok, 1'b1);
      cmd(8'h04); #1;
      chk("R10 no WEL denies", pe_ok, 1'b0);
   endtask

   task automatic t_lock;
      wp_n = 1'b0;
      set_stat(8'h88);
      chk("R7 BPL and BP in one write", stat_q, 8'h88);
      set_stat(8'h00);
      chk("R6 locked write ignored", stat_q, 8'h88);
      wp_n = 1'b1;
      set_stat(8'h04);
      chk("R7 pin high unlocks", stat_q, 8'h04);
   endtask

   task automatic t_aai;
      cmd(8'h06);
      cmd(8'hAD);
      chk("R4 AAI sets flag", stat_q, 8'h46);
      cmd(8'h04);
      chk("R3 WRDI clears WEL and AAI", stat_q, 8'h04);
      cmd(8'hAD);
      chk("R4 AAI without WEL", stat_q[6], 1'b0);
      cmd(8'h06);
      cmd(8'hAD);
      @(negedge clk); aai_end = 1'b1;
      @(negedge clk); aai_end = 1'b0;
      chk("R4 end clears WEL and AAI", stat_q, 8'h04);
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_wel;
      t_arm;
      t_prot;
      t_lock;
      t_aai;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule